// File: doc/BRIEF.md
# Window Watchdog Timer

This block is a watchdog with a legal restart window, reached through a plain 32-bit register bus: a byte address, a write strobe, write data and combinational read data. Software loads two counts in clock cycles. After the watchdog is enabled, a guard interval (the closed window) runs first, and a restart ("kick") is forbidden during it. A service interval (the open window) follows, and a kick is accepted during it. A kick in the open window starts the sequence again from a fresh guard interval. A kick that comes too early, or an open window that runs out, raises a one-cycle reset request and sets a sticky fault flag. The flag is also driven out as an interrupt level.

While the watchdog runs, its control registers are guarded by a single-use unlock. Software writes 1 to the unlock register, and the next accepted write to a guarded register spends that unlock. While the watchdog is disabled, the guarded registers take writes freely. Software can therefore stop the timer, reload both counts and start it again with a read-modify-write of the control word.

Word offsets: 0x00 unlock, 0x04 control/status, 0x08 reserved, 0x0C guard count, 0x10 service count. Offsets that are not word-aligned match nothing.

Top module: `wwd_timer`

## Requirements
- R1: After reset, every register reads 0, the watchdog is disabled, the unlock is clear, and `rst_req` and `irq` are low.
- R2: Writing offset 0x00 loads its bit 0 into the unlock, and the unlock reads back at bit 0 of 0x00. The first accepted write to a guarded register (0x04, 0x0C, 0x10) clears the unlock.
- R3: While the watchdog is enabled and the unlock is clear, writes to guarded registers are ignored: readback does not change, and no kick and no disable take effect. While the watchdog is disabled, guarded writes are accepted without an unlock.
- R4: Bit 0 of 0x04 is the enable. Let E be the clock edge that accepts the enabling write, C the guard count and O the service count, with a count of 0 behaving as 1. With no kick, `rst_req` is high in the cycle after edge E+C+O+1.
- R5: A kick is an accepted write to 0x04 with bit 8 and bit 0 both set while the watchdog is enabled. A kick on an edge where the guard interval is running raises `rst_req` in the next cycle and sets the fault flag. A new guard interval then starts at that edge.
- R6: A kick on an edge where the service interval is running raises no `rst_req` and starts a new guard interval. The next expiry then comes C+O edges after the kick edge. A kick on the last service cycle wins over expiry.
- R7: `rst_req` is a single-cycle pulse. Each fault sets the flag at bit 16 of 0x04 in the same cycle, and `irq` mirrors the flag. After an expiry, a new guard interval starts, so a repeat fault follows C+O edges later.
- R8: An accepted write to 0x04 with bit 16 set clears the flag. A fault on the same edge takes precedence and leaves the flag set.
- R9: Bit 8 of 0x04 always reads 0. Offset 0x08 always reads 0 and ignores writes.
- R10: Clearing the enable stops the timer: `rst_req` stays low while the watchdog is disabled. Re-enabling starts from a fresh guard interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| rst_req | output | 1 | One-cycle reset request on a fault |
| irq | output | 1 | Sticky fault flag level |

## Verification
The bench sweeps the grid of guard and service counts 1 to 4, plus a zero-count case. For each pair it measures the edge of the first expiry and of the repeat expiry, which distinguishes off-by-one errors in either window from faults in the reload. For every pair it also places one kick on each edge from the first guard cycle through the final service cycle. The single-cycle boundary between a premature and a legal kick is exercised, along with the case where a kick and expiry fall on the same edge. Locked writes, a locked kick and a locked disable are each followed by a readback or a pulse check, which shows that the unlock gates each effect on its own and is spent by one write.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

   // word indices (byte offset / 4); software depends on these
   localparam logic [2:0] IDX_UNLOCK = 3'd0;
   localparam logic [2:0] IDX_CTRL   = 3'd1;
   localparam logic [2:0] IDX_RSVD   = 3'd2;
   localparam logic [2:0] IDX_CLOSED = 3'd3;
   localparam logic [2:0] IDX_OPEN   = 3'd4;

   // control/status bit positions
   localparam int BIT_EN   = 0;
   localparam int BIT_KICK = 8;
   localparam int BIT_FLAG = 16;

   typedef enum logic [1:0] {
      WS_IDLE   = 2'd0,
      WS_CLOSED = 2'd1,
      WS_OPEN   = 2'd2
   } wstate_t;

   typedef struct packed {
      logic unlock;
      logic ctrl;
      logic closed;
      logic open;
   } sel_t;

endpackage

// File: rtl/wwd_decode.sv
module wwd_decode
   import wwd_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_t              hit
);
   localparam int IW = ADDR_W - 2;

   logic [IW-1:0] idx;
   logic          aligned;

   assign idx     = addr[ADDR_W-1:2];
   assign aligned = (addr[1:0] == 2'b00);

   always_comb begin
      hit.unlock = aligned && (idx == IW'(IDX_UNLOCK));
      hit.ctrl   = aligned && (idx == IW'(IDX_CTRL));
      hit.closed = aligned && (idx == IW'(IDX_CLOSED));
      hit.open   = aligned && (idx == IW'(IDX_OPEN));
   end
endmodule

// File: rtl/wwd_access.sv
module wwd_access (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_unlock,
   input  logic wr_prot,
   input  logic unlock_bit,
   input  logic enabled,
   output logic unlock_q,
   output logic accept
);
   // guarded write passes with a live unlock, or whenever the timer is stopped
   assign accept = wr_prot & (unlock_q | ~enabled);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         unlock_q <= 1'b0;
      end else if (wr_unlock) begin
         unlock_q <= unlock_bit;
      end else if (accept) begin
         unlock_q <= 1'b0;
      end
   end
endmodule

// File: rtl/wwd_regs.sv
module wwd_regs
   import wwd_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sel_t              hit,
   input  logic              accept,
   input  logic [DATA_W-1:0] wdata,
   input  logic              unlock_q,
   input  logic              fault,
   output logic              en_q,
   output logic [CNT_W-1:0]  closed_q,
   output logic [CNT_W-1:0]  open_q,
   output logic              flag_q,
   output logic              kick,
   output logic [DATA_W-1:0] rdata
);
   logic              wr_ctrl;
   logic [DATA_W-1:0] closed_rd;
   logic [DATA_W-1:0] open_rd;

   assign wr_ctrl = accept & hit.ctrl;
   // kick keeps the timer enabled and only counts while it already runs
   assign kick    = wr_ctrl & wdata[BIT_KICK] & wdata[BIT_EN] & en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         closed_q <= '0;
         open_q   <= '0;
         flag_q   <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            en_q <= wdata[BIT_EN];
         end
         if (accept && hit.closed) begin
            closed_q <= wdata[CNT_W-1:0];
         end
         if (accept && hit.open) begin
            open_q <= wdata[CNT_W-1:0];
         end
         if (fault) begin
            flag_q <= 1'b1;
         end else if (wr_ctrl && wdata[BIT_FLAG]) begin
            flag_q <= 1'b0;
         end
      end
   end

   generate
      if (CNT_W < DATA_W) begin : g_pad
         assign closed_rd = {{(DATA_W-CNT_W){1'b0}}, closed_q};
         assign open_rd   = {{(DATA_W-CNT_W){1'b0}}, open_q};
      end else begin : g_full
         assign closed_rd = closed_q;
         assign open_rd   = open_q;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (hit.unlock) begin
         rdata[0] = unlock_q;
      end
      if (hit.ctrl) begin
         rdata[BIT_EN]   = en_q;
         rdata[BIT_FLAG] = flag_q;
      end
      if (hit.closed) begin
         rdata = closed_rd;
      end
      if (hit.open) begin
         rdata = open_rd;
      end
   end
endmodule

// File: rtl/wwd_window.sv
module wwd_window
   import wwd_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             kick,
   input  logic [CNT_W-1:0] closed_cnt,
   input  logic [CNT_W-1:0] open_cnt,
   output logic             fault,
   output logic             rst_req
);
   wstate_t          st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last;

   // a count of 0 or 1 both mean a single cycle
   assign last  = (cnt_q <= CNT_W'(1));
   assign fault = enable & (((st_q == WS_CLOSED) & kick) |
                            ((st_q == WS_OPEN) & ~kick & last));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= WS_IDLE;
         cnt_q   <= '0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= fault;
         if (!enable) begin
            st_q  <= WS_IDLE;
            cnt_q <= '0;
         end else begin
            unique case (st_q)
               WS_CLOSED: begin
                  if (kick) begin
                     cnt_q <= closed_cnt;
                  end else if (last) begin
                     st_q  <= WS_OPEN;
                     cnt_q <= open_cnt;
                  end else begin
                     cnt_q <= cnt_q - CNT_W'(1);
                  end
               end
               WS_OPEN: begin
                  if (kick || last) begin
                     st_q  <= WS_CLOSED;
                     cnt_q <= closed_cnt;
                  end else begin
                     cnt_q <= cnt_q - CNT_W'(1);
                  end
               end
               default: begin
                  st_q  <= WS_CLOSED;
                  cnt_q <= closed_cnt;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/wwd_timer.sv
module wwd_timer
   import wwd_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              rst_req,
   output logic              irq
);
   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("wwd_timer: ADDR_W must reach offset 0x10");
      end
      if (DATA_W < BIT_FLAG + 1) begin : g_bad_data
         $error("wwd_timer: DATA_W must hold the flag bit");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("wwd_timer: CNT_W must be 1..DATA_W");
      end
   endgenerate

   sel_t             hit;
   logic             unlock_q;
   logic             accept;
   logic             en_q;
   logic [CNT_W-1:0] closed_q;
   logic [CNT_W-1:0] open_q;
   logic             flag_q;
   logic             kick;
   logic             fault;
   logic             wr_prot;

   assign wr_prot = bus_we & (hit.ctrl | hit.closed | hit.open);

   wwd_decode #(.ADDR_W(ADDR_W)) dec_i (
      .addr (bus_addr),
      .hit  (hit)
   );

   wwd_access acc_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_unlock  (bus_we & hit.unlock),
      .wr_prot    (wr_prot),
      .unlock_bit (bus_wdata[0]),
      .enabled    (en_q),
      .unlock_q   (unlock_q),
      .accept     (accept)
   );

   wwd_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .accept   (accept),
      .wdata    (bus_wdata),
      .unlock_q (unlock_q),
      .fault    (fault),
      .en_q     (en_q),
      .closed_q (closed_q),
      .open_q   (open_q),
      .flag_q   (flag_q),
      .kick     (kick),
      .rdata    (bus_rdata)
   );

   wwd_window #(.CNT_W(CNT_W)) win_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (en_q),
      .kick       (kick),
      .closed_cnt (closed_q),
      .open_cnt   (open_q),
      .fault      (fault),
      .rst_req    (rst_req)
   );

   assign irq = flag_q;
endmodule

// File: rtl/wwd_timer_chk.sv
module wwd_timer_chk #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              rst_req,
   input logic              irq,
   input logic              unlock_q,
   input logic              en_q,
   input logic [CNT_W-1:0]  closed_q
);
   logic ctrl_a, closed_a, open_a, rsvd_a, prot_a;

   assign ctrl_a   = (bus_addr == ADDR_W'(4));
   assign rsvd_a   = (bus_addr == ADDR_W'(8));
   assign closed_a = (bus_addr == ADDR_W'(12));
   assign open_a   = (bus_addr == ADDR_W'(16));
   assign prot_a   = ctrl_a | closed_a | open_a;

   AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R7
   AST_FAULT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> irq); // R7
   AST_UNLOCK_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && prot_a && unlock_q) |=> !unlock_q); // R2
   AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && closed_a && !unlock_q && en_q) |=> $stable(closed_q)); // R3
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !rst_req); // R10
   AST_KICK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_a |-> !bus_rdata[8]); // R9
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsvd_a |-> (bus_rdata == '0)); // R9
endmodule

bind wwd_timer wwd_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_rdata (bus_rdata),
   .rst_req   (rst_req),
   .irq       (irq),
   .unlock_q  (unlock_q),
   .en_q      (en_q),
   .closed_q  (closed_q)
);

// File: tb/wwd_timer_tb_top.sv
module wwd_timer_tb_top;
   localparam int AW = 5;
   localparam int DW = 32;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          we = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rst_req;
   logic          irq;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   wwd_timer #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (addr),
      .bus_we    (we),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .rst_req   (rst_req),
      .irq       (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic restart(input int c, input int o);
      wr(5'h00, 32'h1);
      wr(5'h04, 32'h1_0000);
      wr(5'h0C, c);
      wr(5'h10, o);
      wr(5'h04, 32'h1);
   endtask

   // pulse expected exactly at the n-th edge from here, low before it
   task automatic expect_pulse(input string req, input int n);
      for (int i = 1; i <= n; i++) begin
         step();
         chk(req, rst_req, (i == n));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R4 watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();

      // R1 reset state
      for (int a = 0; a <= 16; a += 4) begin
         rd(AW'(a), v);
         chk("R1 register", v, 0);
      end
      chk("R1 rst_req", rst_req, 0);
      chk("R1 irq", irq, 0);

      // R2 unlock readback
      wr(5'h00, 32'h1); rd(5'h00, v); chk("R2 unlock set", v, 1);
      wr(5'h00, 32'h0); rd(5'h00, v); chk("R2 unlock clear", v, 0);

      // R3 free writes while disabled
      wr(5'h0C, 5); rd(5'h0C, v); chk("R3 guard count", v, 5);
      wr(5'h10, 7); rd(5'h10, v); chk("R3 service count", v, 7);

      // R9 reserved word
      wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, v); chk("R9 reserved", v, 0);

      // enable, then locked accesses
      wr(5'h04, 32'h1); rd(5'h04, v); chk("R4 enable readback", v, 1);
      wr(5'h0C, 9); rd(5'h0C, v); chk("R3 locked count write", v, 5);
      wr(5'h04, 32'h101); chk("R3 locked kick", rst_req, 0);
      wr(5'h04, 32'h0); rd(5'h04, v); chk("R3 locked disable", v[0], 1);
      wr(5'h00, 32'h1); wr(5'h0C, 9); rd(5'h0C, v); chk("R3 unlocked write", v, 9);
      rd(5'h00, v); chk("R2 unlock spent", v, 0);

      // R10 disable stops everything
      wr(5'h00, 32'h1); wr(5'h04, 32'h0);
      rd(5'h04, v); chk("R10 disabled", v[0], 0);
      seen = 0;
      for (int i = 0; i < 40; i++) begin
         step();
         if (rst_req) seen++;
      end
      chk("R10 quiet", seen, 0);

      // R4 / R7 expiry grid
      for (int c = 1; c <= 4; c++) begin
         for (int o = 1; o <= 4; o++) begin
            restart(c, o);
            expect_pulse("R4 expiry", c + o + 1);
            chk("R7 irq", irq, 1);
            rd(5'h04, v); chk("R7 flag", v, 32'h1_0001);
            expect_pulse("R7 repeat", c + o);
         end
      end

      // R4 zero counts act as one
      restart(0, 0);
      expect_pulse("R4 zero count", 3);

      // R8 flag clear, R9 kick bit reads zero
      restart(2, 2);
      expect_pulse("R7 expiry", 5);
      wr(5'h00, 32'h1);
      wr(5'h04, 32'h1_0001);
      rd(5'h04, v); chk("R8 flag cleared", v, 1);
      chk("R8 irq low", irq, 0);
      wr(5'h00, 32'h1);
      wr(5'h04, 32'h101);
      chk("R6 kick on last cycle", rst_req, 0);
      rd(5'h04, v); chk("R9 kick reads zero", v, 1);

      // R5 / R6 kick position sweep
      for (int c = 1; c <= 4; c++) begin
         for (int o = 1; o <= 4; o++) begin
            for (int d = 2; d <= c + o + 1; d++) begin
               restart(c, o);
               for (int i = 0; i < d - 2; i++) begin
                  step();
                  chk("R4 no early pulse", rst_req, 0);
               end
               wr(5'h00, 32'h1);
               chk("R4 no early pulse", rst_req, 0);
               wr(5'h04, 32'h101);
               if (d - 1 <= c) begin
                  chk("R5 premature kick", rst_req, 1);
                  chk("R5 flag", irq, 1);
                  expect_pulse("R5 restart", c + o);
               end else begin
                  chk("R6 legal kick", rst_req, 0);
                  expect_pulse("R6 reload", c + o);
               end
            end
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule